// File: doc/BRIEF.md
# Sampling Converter Host-Bus Interface

This block is the digital front end that a host processor sees when it talks to a 12-bit sampling converter. It turns the host's conversion-start strobe, chip select, read and byte-select lines into a hold command for the sampling stage. It also raises a status line and presents the conversion result on a parallel data bus, either as one 12-bit word or as two bytes. The converter core is a behavioural stand-in. It captures the digital `sample_in` word when a conversion starts and returns it as the result a fixed number of clocks later.

There are two ways to use the block. In strobe mode a timer pulses `conv_start_n` low, and the conversion begins on the rising edge of that pulse. The status line then acts as an end-of-conversion interrupt, which the host clears by reading. In chip-select mode `conv_start_n` is tied low. Taking chip select low with the byte select low starts the conversion, and the status line shows busy. A read that starts a conversion stalls with the bus released until the result is ready, like a slow memory.

The host inputs are asynchronous and pass through two-flop synchronizers. An edge on a host input therefore acts on the third rising clock edge after it.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `hold` is low, `data_oe` is low, and `status_n` is low because an interrupt is pending from power-up.
- R2: In strobe mode, a rising edge on `conv_start_n` starts a conversion when the block is idle, and `hold` goes high on the third rising clock edge after that input edge.
- R3: `hold` stays high for exactly CONV_CYCLES clocks and then drops, and the new result is loaded into the output latch on the same edge.
- R4: After a strobe-mode conversion, `status_n` goes low as `hold` drops and stays low until chip select and read are both seen low together. Reads clear the interrupt pending from power-up the same way.
- R5: With `conv_start_n` held low, a falling edge on `cs_n` starts a conversion only if `byte_sel` is low at that moment. A falling edge with `byte_sel` high is an ordinary read and starts nothing.
- R6: During a chip-select-mode conversion `status_n` is low (busy), and it returns high when the conversion completes.
- R7: `data_oe` is high only when the synchronized `cs_n` and `rd_n` are both low and no conversion is in progress. `data_out` is all zeros whenever `data_oe` is low.
- R8: With `word_fmt` high, an enabled read presents the full 12-bit result on `data_out`.
- R9: With `word_fmt` low and `byte_sel` low, the read presents result bits 7..0 on `data_out[7:0]`, with `data_out[11:8]` zero.
- R10: With `word_fmt` low and `byte_sel` high, the read presents result bits 11..8 on `data_out[3:0]`, with `data_out[11:4]` zero.
- R11: A start request that arrives while a conversion is running is ignored. The running conversion keeps its length and nothing restarts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_n | input | 1 | Conversion-start strobe, asynchronous; tied low for chip-select mode |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| byte_sel | input | 1 | Selects the high byte in byte format; must be low for a chip-select start |
| word_fmt | input | 1 | 1 = 12-bit word reads, 0 = two byte reads; quasi-static |
| sample_in | input | 12 | Digital stand-in for the analog input, captured at conversion start |
| hold | output | 1 | High while the sampling stage holds, i.e. during a conversion |
| status_n | output | 1 | Interrupt (strobe mode) or busy (chip-select mode), active low |
| data_out | output | 12 | Read data bus value |
| data_oe | output | 1 | Bus drive enable; low models high impedance |

## Verification
The assertions assume that `word_fmt` changes only while no read is active. They also assume `byte_sel` reaches its new level no later than a `cs_n` falling edge that is meant to start a conversion. The stimulus changes all inputs only on falling clock edges. It holds each level for at least two clocks and moves `word_fmt` only while chip select is high. Strobe pulses are issued only with chip select idle, so no strobe edge and chip-select edge ever land in the same cycle.

// File: rtl/adc_bus_pkg.sv
// Package: shared types for the converter bus interface.
// Assumes nothing beyond standard SystemVerilog.
package adc_bus_pkg;

    // How the running conversion was started; selects the status pin role.
    typedef enum logic {
        MODE_STROBE  = 1'b0,
        MODE_CHIPSEL = 1'b1
    } conv_mode_e;

    // Bit positions of the packed asynchronous host inputs.
    localparam int unsigned IDX_BSEL = 0;
    localparam int unsigned IDX_RD   = 1;
    localparam int unsigned IDX_CS   = 2;
    localparam int unsigned IDX_CONV = 3;
    localparam int unsigned HOST_IN_W = 4;

endpackage

// File: rtl/adc_sync2.sv
// Module: two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a separate level signal; no multi-bit coherence is implied.
module adc_sync2 #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    // Two register stages per bit, reset to the idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/adc_core_stub.sv
// Module: behavioural stand-in for the successive-approximation core.
// Captures the sample on start, and after CONV_CYCLES clocks pulses done and loads the result latch.
// Assumes start is a single-cycle request; requests while running are dropped.
module adc_core_stub #(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] sample_in,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    logic              running_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sample_q;

    assign done = running_q && (cnt_q == '0);

    // Conversion timer and sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            sample_q  <= '0;
        end else if (running_q) begin
            if (cnt_q == '0) running_q <= 1'b0;
            else             cnt_q     <= cnt_q - 1'b1;
        end else if (start) begin
            running_q <= 1'b1;
            cnt_q     <= CNT_LAST;
            sample_q  <= sample_in;
        end
    end

    // Output latch: updated only when a conversion finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (done) result <= sample_q;
    end

    // R11: a running conversion is never restarted; the timer only counts down.
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && cnt_q != '0) |=> (running_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_conv_ctrl.sv
// Module: start detection, hold control and the dual-role status line.
// Assumes synchronized, glitch-free inputs; the conv and chip-select starts are mutually exclusive
// because one needs conv high and the other conv low.
module adc_conv_ctrl
    import adc_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_s,
    input  logic       cs_s,
    input  logic       rd_s,
    input  logic       bsel_s,
    input  logic       done,
    output logic       start,
    output logic       busy,
    output conv_mode_e mode,
    output logic       status_n
);
    logic conv_d, cs_d, rdact_d, int_pend_q;
    logic conv_rise, cs_fall, rdact, rdact_rise, cs_start;

    assign conv_rise  = conv_s && !conv_d;
    assign cs_fall    = !cs_s && cs_d;
    assign rdact      = !cs_s && !rd_s;
    assign rdact_rise = rdact && !rdact_d;
    assign cs_start   = cs_fall && !bsel_s && !conv_s;
    assign start      = !busy && (conv_rise || cs_start);

    // Edge-detect history of the synchronized inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_d  <= 1'b1;
            cs_d    <= 1'b1;
            rdact_d <= 1'b0;
        end else begin
            conv_d  <= conv_s;
            cs_d    <= cs_s;
            rdact_d <= rdact;
        end
    end

    // Busy flag and the record of which input started the conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            mode <= MODE_STROBE;
        end else if (busy) begin
            if (done) busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            mode <= conv_rise ? MODE_STROBE : MODE_CHIPSEL;
        end
    end

    // Interrupt latch: pending from power-up, set at a strobe-mode end, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                int_pend_q <= 1'b1;
        else if (done && mode == MODE_STROBE)      int_pend_q <= 1'b1;
        else if (rdact_rise)                       int_pend_q <= 1'b0;
    end

    assign status_n = !((busy && mode == MODE_CHIPSEL) || int_pend_q);

    // R4: the end of a strobe-mode conversion leaves the interrupt asserted.
    a_r4_int_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy && mode == MODE_STROBE) |=> !status_n);

    // R5: a chip-select-mode conversion only begins with the byte select low.
    a_r5_low_byte_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && mode == MODE_CHIPSEL) |-> $past(!bsel_s));
endmodule

// File: rtl/adc_read_mux.sv
// Module: read-data formatting and bus enable.
// Assumes word_fmt only changes while no read is active.
module adc_read_mux #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DATA_W-1:0] result,
    input  logic              word_fmt,
    input  logic              bsel_s,
    input  logic              cs_s,
    input  logic              rd_s,
    input  logic              busy,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam int unsigned HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] fmt_val;

    // Select word, low byte or right-aligned high part.
    always_comb begin
        if (word_fmt)    fmt_val = result;
        else if (bsel_s) fmt_val = {{(DATA_W-HI_W){1'b0}}, result[DATA_W-1:BYTE_W]};
        else             fmt_val = {{(DATA_W-BYTE_W){1'b0}}, result[BYTE_W-1:0]};
    end

    // Drive only during an active read outside a conversion.
    always_comb begin
        data_oe  = !cs_s && !rd_s && !busy;
        data_out = data_oe ? fmt_val : '0;
    end
endmodule

// File: rtl/adc_bus_ctrl.sv
// Module: top of the converter host-bus interface.
// Synchronizes the host inputs, detects starts, runs the core stub and formats read data.
// Assumes word_fmt is quasi-static and sample_in is stable at the start edge.
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              byte_sel,
    input  logic              word_fmt,
    input  logic [DATA_W-1:0] sample_in,
    output logic              hold,
    output logic              status_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam logic [HOST_IN_W-1:0] HOST_IDLE = 4'b1110;

    logic [HOST_IN_W-1:0] host_raw, host_s;
    logic                 start, busy, done;
    logic [DATA_W-1:0]    result;
    conv_mode_e           mode;

    assign host_raw = {conv_start_n, cs_n, rd_n, byte_sel};

    adc_sync2 #(.W(HOST_IN_W), .RST_VAL(HOST_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(host_raw), .sync_out(host_s)
    );

    adc_conv_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .conv_s(host_s[IDX_CONV]), .cs_s(host_s[IDX_CS]),
        .rd_s(host_s[IDX_RD]), .bsel_s(host_s[IDX_BSEL]),
        .done(done), .start(start), .busy(busy), .mode(mode),
        .status_n(status_n)
    );

    adc_core_stub #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .sample_in(sample_in),
        .done(done), .result(result)
    );

    adc_read_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mux (
        .result(result), .word_fmt(word_fmt), .bsel_s(host_s[IDX_BSEL]),
        .cs_s(host_s[IDX_CS]), .rd_s(host_s[IDX_RD]), .busy(busy),
        .data_out(data_out), .data_oe(data_oe)
    );

    assign hold = busy;

    // R7: the bus is never driven while the sampling stage holds.
    a_r7_no_drive_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !hold);

    // R3: hold drops exactly when the core reports completion.
    a_r3_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(done));
endmodule

// File: tb/adc_bus_ctrl_test.sv
module adc_bus_ctrl_test;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, byte_sel = 1'b0, word_fmt = 1'b1;
    logic [11:0] sample_in = '0;
    logic hold, status_n, data_oe;
    logic [11:0] data_out;

    int vecs = 0, fails = 0, cyc = 0, holdcnt = 0;
    bit done_run = 0;

    adc_bus_ctrl #(.DATA_W(12), .BYTE_W(8), .CONV_CYCLES(N)) uut (
        .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .cs_n(cs_n),
        .rd_n(rd_n), .byte_sel(byte_sel), .word_fmt(word_fmt), .sample_in(sample_in),
        .hold(hold), .status_n(status_n), .data_out(data_out), .data_oe(data_oe)
    );

    always #5 clk = ~clk;

    // Reference model state (behavioural, integer based).
    int  m_cnt;
    bit  m_busy, m_mode2, m_int, m_rdprev;
    int  m_res, m_smp;
    bit  c1, c2, c3, s1, s2, s3, r1, r2, b1, b2;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model update on every clock edge.
    always @(posedge clk) begin
        bit conv_rise, cs_fall, rdact, fin;
        if (!rst_n) begin
            m_busy = 0; m_mode2 = 0; m_int = 1; m_rdprev = 0; m_cnt = 0;
            m_res = 0; m_smp = 0;
            c1 = 1; c2 = 1; c3 = 1; s1 = 1; s2 = 1; s3 = 1; r1 = 1; r2 = 1; b1 = 0; b2 = 0;
        end else begin
            conv_rise = c2 && !c3;
            cs_fall   = !s2 && s3;
            rdact     = !s2 && !r2;
            fin = 0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0; m_res = m_smp; fin = 1;
                end else m_cnt--;
            end else if (conv_rise || (cs_fall && !b2 && !c2)) begin
                m_busy = 1; m_cnt = N - 1; m_smp = sample_in; m_mode2 = !conv_rise;
            end
            if (fin && !m_mode2) m_int = 1;
            else if (rdact && !m_rdprev) m_int = 0;
            m_rdprev = rdact;
            c3 = c2; c2 = c1; c1 = conv_start_n;
            s3 = s2; s2 = s1; s1 = cs_n;
            r2 = r1; r1 = rd_n;
            b2 = b1; b1 = byte_sel;
        end
        cyc++;
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            bit e_oe; int e_dat; string dtag;
            e_oe = !s2 && !r2 && !m_busy;
            if (!e_oe) begin e_dat = 0; dtag = "R7"; end
            else if (word_fmt) begin e_dat = m_res; dtag = "R8"; end
            else if (b2) begin e_dat = (m_res >> 8) & 'hF; dtag = "R10"; end
            else begin e_dat = m_res & 'hFF; dtag = "R9"; end
            chk(hold == m_busy, m_mode2 ? "R5 hold" : "R2 hold", hold, m_busy);
            chk(status_n == !((m_busy && m_mode2) || m_int), m_mode2 ? "R6 status" : "R4 status",
                status_n, !((m_busy && m_mode2) || m_int));
            chk(data_oe == e_oe, "R7 oe", data_oe, e_oe);
            chk(data_out == e_dat, dtag, data_out, e_dat);
            if (hold) holdcnt++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000 && !done_run) begin
            done_run = 1;
            fails++;
            $display("FAIL watchdog R3 act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) conv_start_n = 1'b0;
        idle(2);
        conv_start_n = 1'b1;
    endtask

    task automatic bus_read(input bit bs, input int n, output logic [11:0] d);
        @(negedge clk) byte_sel = bs;
        idle(2);
        cs_n = 1'b0; rd_n = 1'b0;
        idle(n);
        d = data_out;
        cs_n = 1'b1; rd_n = 1'b1;
        idle(4);
    endtask

    initial begin
        logic [11:0] d;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk(hold == 0, "R1 hold", hold, 0);
        chk(status_n == 0, "R1 status", status_n, 0);
        chk(data_oe == 0, "R1 oe", data_oe, 0);

        // R4: dummy read clears the power-up interrupt
        bus_read(0, 5, d);
        chk(status_n == 1, "R4 clear", status_n, 1);

        // R2/R3/R8: strobe-mode word conversion
        sample_in = 12'hA5C; holdcnt = 0;
        strobe();
        idle(2);
        chk(hold == 0, "R2 early", hold, 0);
        idle(1);
        chk(hold == 1, "R2 start", hold, 1);
        idle(N + 4);
        chk(holdcnt == N, "R3 length", holdcnt, N);
        chk(status_n == 0, "R4 int", status_n, 0);
        bus_read(0, 5, d);
        chk(d == 12'hA5C, "R8 word", d, 12'hA5C);
        chk(status_n == 1, "R4 cleared", status_n, 1);

        // R9/R10: strobe-mode byte reads
        word_fmt = 1'b0; sample_in = 12'h3B7;
        strobe();
        idle(N + 6);
        bus_read(0, 5, d);
        chk(d == 12'h0B7, "R9 low byte", d, 12'h0B7);
        bus_read(1, 5, d);
        chk(d == 12'h003, "R10 high part", d, 12'h003);

        // R11: second strobe during conversion is ignored
        sample_in = 12'h5A1; holdcnt = 0;
        strobe();
        idle(4);
        sample_in = 12'h0FF;
        strobe();
        idle(N + 8);
        chk(holdcnt == N, "R11 length", holdcnt, N);
        word_fmt = 1'b1;
        bus_read(0, 5, d);
        chk(d == 12'h5A1, "R11 result", d, 12'h5A1);

        // R5/R6: chip-select mode, slow-memory word read
        conv_start_n = 1'b0; sample_in = 12'h7E1; byte_sel = 1'b0;
        idle(4);
        cs_n = 1'b0; rd_n = 1'b0;
        idle(10);
        chk(status_n == 0, "R6 busy", status_n, 0);
        chk(data_oe == 0, "R7 oe in conv", data_oe, 0);
        idle(N);
        chk(status_n == 1, "R6 release", status_n, 1);
        chk(data_out == 12'h7E1, "R5 word", data_out, 12'h7E1);
        cs_n = 1'b1; rd_n = 1'b1;
        idle(4);

        // R5: byte select high means no conversion
        holdcnt = 0; sample_in = 12'h111;
        bus_read(1, 8, d);
        chk(holdcnt == 0, "R5 no start", holdcnt, 0);
        chk(d == 12'h7E1, "R5 ordinary read", d, 12'h7E1);

        // R9/R10: chip-select mode byte pair
        word_fmt = 1'b0; sample_in = 12'hC4D;
        bus_read(0, N + 8, d);
        chk(d == 12'h04D, "R9 slow low byte", d, 12'h04D);
        bus_read(1, 5, d);
        chk(d == 12'h00C, "R10 high part", d, 12'h00C);

        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule